// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block is a small fully associative translation cache that maps virtual page numbers to physical frame numbers for 4 KiB pages. Each lookup carries a virtual page number, a load/store flag and the program counter of the access. One cycle later the block returns either a translation or exactly one of three faults. A refill fault means no entry matched. An invalid fault means the matching entry is marked not valid. A modify fault means a store hit an entry that is valid but not writable.

The hardware never walks page tables and never alters an entry. Software keeps entries up to date through a register port. It loads a page-number register (entry-high) and a frame/flag register (entry-low). It then issues either a random-write command, which fills a slot picked by a free-running down-counter that avoids a programmable number of low "pinned" slots, or an indexed-write command, which fills a chosen slot. On any fault the block latches the faulting page number into a context register, beside a software-owned table base, and latches the faulting PC into an exception-PC register. A refill handler can then load the page-table entry with a single memory read.

Top module: `soft_tlb`

## Requirements
- R1: After reset no slot holds a translation, so every lookup reports a refill fault. The exception-PC register reads 0.
- R2: A load or store that matches a valid entry, and is permitted by it, asserts `rsp_hit` with the entry's frame number on `rsp_pfn`, one clock after the lookup is presented, with no fault.
- R3: A lookup matching no slot asserts only `exc_refill`, one clock after the lookup.
- R4: A lookup matching an entry whose valid bit (entry-low bit 1) is clear asserts only `exc_invalid`, for loads and stores alike.
- R5: A store matching a valid entry whose writable bit (entry-low bit 2) is clear asserts only `exc_modify`. A load to that entry is translated normally.
- R6: At most one fault output is high per lookup, with priority refill over invalid over modify. `rsp_done` is high exactly one clock after every lookup.
- R7: On any fault, the context register (select 4) reads {table base in bits 31:22, faulting page number in bits 21:2, 2'b00}, and the exception-PC register (select 5) reads the faulting PC. Lookups that do not fault leave both unchanged.
- R8: The random index (select 3) counts down by one each clock from ENTRIES-1 to the pinned count (select 6) and then wraps to ENTRIES-1. It restarts at ENTRIES-1 when the pinned count is written. A random write fills the slot the random index names.
- R9: An indexed write fills the slot held in the index register (select 2) from entry-high (page number in bits 31:12) and entry-low (frame in bits 31:12, flags as in R4/R5).
- R10: Lookups never modify an entry. A store that takes a modify fault faults again on retry, and pinned slots survive any number of random writes.
- R11: Register reads return, one clock after the select is presented, the value last written to entry-high, entry-low, index, table base or pinned count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| lk_pc | input | 32 | PC of the accessing instruction |
| rsp_done | output | 1 | Lookup result is present this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_pfn | output | 20 | Physical frame number on a hit, else 0 |
| exc_refill | output | 1 | No matching slot |
| exc_invalid | output | 1 | Matching slot not valid |
| exc_modify | output | 1 | Store to non-writable slot |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 hi, 1 lo, 2 index, 3 random, 4 context, 5 exception PC, 6 pinned count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's select |
| wr_random | input | 1 | Write entry-high/low into the random slot |
| wr_indexed | input | 1 | Write entry-high/low into the indexed slot |

## Verification
A corrupted slot or a wrong match priority shows up at the next lookup of that page, one clock later, as a wrong frame or the wrong fault line. A random index that strays into the pinned range is not visible right away. It appears only when a later lookup of a pinned page misses, so the bench fills pinned slots first, then issues many random writes, then probes the pinned pages. A context or exception-PC register that updates on non-faulting lookups appears on the next read of those registers, so each fault is followed by a clean hit and a read-back.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DW = 32;
  localparam int LO_WR_BIT = 2;
  localparam int LO_V_BIT  = 1;

  typedef enum logic [2:0] {
    RS_HI    = 3'd0,
    RS_LO    = 3'd1,
    RS_IDX   = 3'd2,
    RS_RND   = 3'd3,
    RS_CTX   = 3'd4,
    RS_EPC   = 3'd5,
    RS_WIRED = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wired_set,
  input  logic [IW-1:0] wired,
  output logic [IW-1:0] rnd
);
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || wired_set) rnd <= TOP;
    else if (rnd <= wired) rnd <= TOP;
    else rnd <= rnd - 1'b1;
  end

  // R8: the victim never falls into the pinned range
  a_r8_rnd_range: assert property (@(posedge clk) disable iff (rst)
    !$past(wired_set) |-> (rnd >= wired));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [VPN_W-1:0] wvpn,
  input  logic [PFN_W-1:0] wpfn,
  input  logic             wvalid,
  input  logic             wwrite,
  input  logic [VPN_W-1:0] lvpn,
  output logic             hit,
  output logic [PFN_W-1:0] hpfn,
  output logic             hvalid,
  output logic             hwrite
);
  logic [VPN_W-1:0] vpn_mem [ENTRIES];
  logic [PFN_W-1:0] pfn_mem [ENTRIES];
  logic [ENTRIES-1:0] v_mem, w_mem, present, match;

  always_ff @(posedge clk) begin
    if (we) begin
      vpn_mem[widx] <= wvpn;
      pfn_mem[widx] <= wpfn;
      v_mem[widx]   <= wvalid;
      w_mem[widx]   <= wwrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) present <= '0;
    else if (we) present[widx] <= 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = present[i] && (vpn_mem[i] == lvpn);
  end

  always_comb begin
    hit = 1'b0; hpfn = '0; hvalid = 1'b0; hwrite = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1; hpfn = pfn_mem[i]; hvalid = v_mem[i]; hwrite = w_mem[i];
      end
    end
  end

  // R10: occupancy only changes on a software write
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(present));
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  input  logic [31:0]      lk_pc,
  output logic             rsp_done,
  output logic             rsp_hit,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             exc_refill,
  output logic             exc_invalid,
  output logic             exc_modify,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             wr_random,
  input  logic             wr_indexed
);
  import tlb_pkg::*;
  localparam int IW     = $clog2(ENTRIES);
  localparam int BASE_W = DW - VPN_W - 2;

  logic [VPN_W-1:0]  hi_vpn, bad_vpn;
  logic [PFN_W-1:0]  lo_pfn;
  logic              lo_v, lo_w;
  logic [IW-1:0]     idx_q, wired_q, rnd;
  logic [BASE_W-1:0] ctx_base;
  logic [31:0]       epc_q;
  logic              wired_set;
  reg_sel_e          sel;

  logic             hit, hv, hw;
  logic [PFN_W-1:0] hpfn;
  logic             f_refill, f_inv, f_mod, ok;

  assign sel       = reg_sel_e'(reg_sel);
  assign wired_set = reg_we && (sel == RS_WIRED);

  tlb_rand_idx #(.ENTRIES(ENTRIES)) u_rnd (
    .clk(clk), .rst(rst), .wired_set(wired_set), .wired(wired_q), .rnd(rnd)
  );

  tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_random || wr_indexed),
    .widx(wr_random ? rnd : idx_q),
    .wvpn(hi_vpn), .wpfn(lo_pfn), .wvalid(lo_v), .wwrite(lo_w),
    .lvpn(lk_vpn), .hit(hit), .hpfn(hpfn), .hvalid(hv), .hwrite(hw)
  );

  // Software-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_vpn <= '0; lo_pfn <= '0; lo_v <= 1'b0; lo_w <= 1'b0;
      idx_q <= '0; wired_q <= '0; ctx_base <= '0;
    end else if (reg_we) begin
      case (sel)
        RS_HI:    hi_vpn <= reg_wdata[31 -: VPN_W];
        RS_LO: begin
          lo_pfn <= reg_wdata[31 -: PFN_W];
          lo_v   <= reg_wdata[LO_V_BIT];
          lo_w   <= reg_wdata[LO_WR_BIT];
        end
        RS_IDX:   idx_q <= reg_wdata[IW-1:0];
        RS_CTX:   ctx_base <= reg_wdata[31 -: BASE_W];
        RS_WIRED: wired_q <= reg_wdata[IW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      case (sel)
        RS_HI:  reg_rdata[31 -: VPN_W] <= hi_vpn;
        RS_LO: begin
          reg_rdata[31 -: PFN_W]  <= lo_pfn;
          reg_rdata[LO_V_BIT]     <= lo_v;
          reg_rdata[LO_WR_BIT]    <= lo_w;
        end
        RS_IDX:   reg_rdata[IW-1:0] <= idx_q;
        RS_RND:   reg_rdata[IW-1:0] <= rnd;
        RS_CTX:   reg_rdata <= {ctx_base, bad_vpn, 2'b00};
        RS_EPC:   reg_rdata <= epc_q;
        RS_WIRED: reg_rdata[IW-1:0] <= wired_q;
        default: ;
      endcase
    end
  end

  // Fault classification with fixed priority
  always_comb begin
    f_refill = lk_valid && !hit;
    f_inv    = lk_valid && hit && !hv;
    f_mod    = lk_valid && hit && hv && lk_store && !hw;
    ok       = lk_valid && hit && hv && !(lk_store && !hw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done <= 1'b0; rsp_hit <= 1'b0; rsp_pfn <= '0;
      exc_refill <= 1'b0; exc_invalid <= 1'b0; exc_modify <= 1'b0;
      bad_vpn <= '0; epc_q <= '0;
    end else begin
      rsp_done    <= lk_valid;
      rsp_hit     <= ok;
      rsp_pfn     <= ok ? hpfn : '0;
      exc_refill  <= f_refill;
      exc_invalid <= f_inv;
      exc_modify  <= f_mod;
      if (f_refill || f_inv || f_mod) begin
        bad_vpn <= lk_vpn;
        epc_q   <= lk_pc;
      end
    end
  end

  // R6: a single fault per lookup
  a_r6_one_fault: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_refill, exc_invalid, exc_modify, rsp_hit}));
  // R6: results only appear for a lookup
  a_r6_done_gate: assert property (@(posedge clk) disable iff (rst)
    (exc_refill || exc_invalid || exc_modify || rsp_hit) |-> rsp_done);
  // R7: the exception PC holds when no lookup is presented
  a_r7_epc_hold: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> $stable(epc_q));
  // R2: a translation answers every request one clock later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_done);
endmodule

// File: tb/soft_tlb_test.sv
module soft_tlb_test;
  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, lk_store = 0;
  logic [19:0] lk_vpn = '0;
  logic [31:0] lk_pc = '0;
  logic rsp_done, rsp_hit, exc_refill, exc_invalid, exc_modify;
  logic [19:0] rsp_pfn;
  logic reg_we = 0, wr_random = 0, wr_indexed = 0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, fails = 0;
  logic [3:0] got; // {refill, invalid, modify, hit}
  logic [19:0] got_pfn;

  always #5 clk = ~clk;

  soft_tlb uut (.*);

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [31:0] d);
    reg_sel = s;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic lookup(input logic [19:0] v, input bit st, input logic [31:0] pc);
    lk_valid = 1; lk_vpn = v; lk_store = st; lk_pc = pc;
    @(posedge clk); @(negedge clk);
    lk_valid = 0;
    got = {exc_refill, exc_invalid, exc_modify, rsp_hit};
    got_pfn = rsp_pfn;
    chk(rsp_done, "R6 done", {31'd0, rsp_done}, 1);
  endtask

  task automatic load_regs(input logic [19:0] v, input logic [19:0] p, input bit vb, input bit wb);
    wreg(0, {v, 12'd0});
    wreg(1, {p, 9'd0, wb, vb, 1'b0});
  endtask

  task automatic put_idx(input int i, input logic [19:0] v, input logic [19:0] p, input bit vb, input bit wb);
    load_regs(v, p, vb, wb);
    wreg(2, i);
    wr_indexed = 1; @(posedge clk); @(negedge clk); wr_indexed = 0;
  endtask

  task automatic put_rnd(input logic [19:0] v, input logic [19:0] p);
    load_regs(v, p, 1, 1);
    wr_random = 1; @(posedge clk); @(negedge clk); wr_random = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rreg(5, d);
    chk(d == 0, "R1 epc", d, 0);
    lookup(20'h00005, 0, 32'h100);
    chk(got == 4'b1000, "R1 R3 refill", got, 4'b1000);
  endtask

  task automatic t_hit;
    logic [31:0] d;
    put_idx(3, 20'h12345, 20'hABCDE, 1, 1);
    rreg(0, d); chk(d == 32'h12345000, "R11 hi", d, 32'h12345000);
    rreg(1, d); chk(d == 32'hABCDE006, "R11 lo", d, 32'hABCDE006);
    rreg(2, d); chk(d == 3, "R11 idx", d, 3);
    lookup(20'h12345, 0, 32'h200);
    chk(got == 4'b0001 && got_pfn == 20'hABCDE, "R2 R9 load", {got, got_pfn}, {4'b0001, 20'hABCDE});
    lookup(20'h12345, 1, 32'h204);
    chk(got == 4'b0001 && got_pfn == 20'hABCDE, "R2 store", {got, got_pfn}, {4'b0001, 20'hABCDE});
  endtask

  task automatic t_context;
    logic [31:0] d;
    wreg(4, {10'h2A5, 22'd0});
    lookup(20'h00777, 0, 32'h80001234);
    chk(got == 4'b1000, "R3 refill", got, 4'b1000);
    lookup(20'h12345, 0, 32'h55550000);
    chk(got == 4'b0001, "R2 hit", got, 4'b0001);
    rreg(4, d);
    chk(d == {10'h2A5, 20'h00777, 2'b00}, "R7 context", d, {10'h2A5, 20'h00777, 2'b00});
    rreg(5, d);
    chk(d == 32'h80001234, "R7 epc", d, 32'h80001234);
  endtask

  task automatic t_invalid;
    put_idx(4, 20'h00100, 20'h11111, 0, 1);
    lookup(20'h00100, 1, 32'h300);
    chk(got == 4'b0100, "R4 R6 store invalid", got, 4'b0100);
    put_idx(6, 20'h00110, 20'h11112, 0, 0);
    lookup(20'h00110, 1, 32'h304);
    chk(got == 4'b0100, "R6 invalid over modify", got, 4'b0100);
    lookup(20'h00100, 0, 32'h308);
    chk(got == 4'b0100, "R4 load invalid", got, 4'b0100);
  endtask

  task automatic t_modify;
    logic [31:0] d;
    put_idx(5, 20'h00200, 20'h22222, 1, 0);
    lookup(20'h00200, 0, 32'h400);
    chk(got == 4'b0001 && got_pfn == 20'h22222, "R5 load ok", {got, got_pfn}, {4'b0001, 20'h22222});
    lookup(20'h00200, 1, 32'h404);
    chk(got == 4'b0010, "R5 modify", got, 4'b0010);
    lookup(20'h00200, 1, 32'h408);
    chk(got == 4'b0010, "R10 still modify", got, 4'b0010);
    rreg(5, d); chk(d == 32'h408, "R7 epc modify", d, 32'h408);
  endtask

  task automatic t_random;
    logic [31:0] a, b;
    wreg(6, 15);
    rreg(3, a); chk(a == 15, "R8 restart", a, 15);
    rreg(6, a); chk(a == 15, "R11 wired", a, 15);
    put_rnd(20'h00300, 20'h33333);
    lookup(20'h00300, 0, 32'h500);
    chk(got == 4'b0001 && got_pfn == 20'h33333, "R8 random write", {got, got_pfn}, {4'b0001, 20'h33333});
    put_idx(15, 20'h00301, 20'h33334, 1, 1);
    lookup(20'h00300, 0, 32'h504);
    chk(got == 4'b1000, "R8 slot was 15", got, 4'b1000);
    wreg(6, 0);
    reg_sel = 3;
    @(posedge clk); @(negedge clk); a = reg_rdata;
    @(posedge clk); @(negedge clk); b = reg_rdata;
    chk((b == a - 1) || (a == 0 && b == 15), "R8 decrement", b, a - 1);
  endtask

  task automatic t_pinned;
    wreg(6, 7);
    for (int k = 0; k < 30; k++) put_rnd(20'h40000 + k, 20'h50000 + k);
    lookup(20'h12345, 0, 32'h600);
    chk(got == 4'b0001 && got_pfn == 20'hABCDE, "R10 R8 pinned 3", {got, got_pfn}, {4'b0001, 20'hABCDE});
    lookup(20'h00200, 1, 32'h604);
    chk(got == 4'b0010, "R10 pinned 5", got, 4'b0010);
    lookup(20'h4001D, 0, 32'h608);
    chk(got == 4'b0001 && got_pfn == 20'h5001D, "R8 last random", {got, got_pfn}, {4'b0001, 20'h5001D});
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset;
    t_hit;
    t_context;
    t_invalid;
    t_modify;
    t_random;
    t_pinned;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule